// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of a free-running timer at the moment a chosen event happens on an external input. The input is passed through a two-stage synchronizer and an edge detector. An optional edge-count prescaler then qualifies the event, and on a qualified event the timer value is written into a capture register. A sticky flag is raised on every capture and stays raised until software clears it.

Software picks the event with a 4-bit mode field. The choices are off, every falling edge, every rising edge, every fourth rising edge and every sixteenth rising edge. The prescaler counter is cleared while the unit is off or in any mode that is not a capture mode. A direct change from one capture mode to another keeps the count, so the first capture after such a change can come early. To start a fresh count, software writes the off mode and then the new mode.

A pin-output-mode input selects the source for the edge detector. When it is set, the port data value is watched instead of the pin, so a write to the port can trigger a capture.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset the capture value is 0, the flag is 0, the mode is off (0000) and the prescaler count is 0.
- R2: Mode codes are 0000 off, 0100 every falling edge, 0101 every rising edge, 0110 every 4th rising edge and 0111 every 16th rising edge. Every other code is a non-capture mode, and in it no capture and no flag set ever happen.
- R3: If the selected source changes before clock edge k, the capture register takes the timer value present at edge k+2. The flag becomes visible after that same edge. `cap_hi_o` holds timer bits 15:8 and `cap_lo_o` holds bits 7:0.
- R4: Mode 0100 captures only on 1-to-0 transitions. Mode 0101 captures only on 0-to-1 transitions.
- R5: Modes 0110 and 0111 capture on the 4th and the 16th rising edge counted since the prescaler was last cleared, and then again every 4 or 16 rising edges.
- R6: The prescaler count is cleared in every cycle in which the mode is not a capture mode. A direct write from one capture mode to another keeps the count, so after the 5 rising edges counted in mode 0111, mode 0110 captures on the 3rd following rising edge.
- R7: The flag stays set until `flag_clr_i` is asserted. A clear with no capture in the same cycle drops the flag at the next edge.
- R8: When a capture and `flag_clr_i` fall in the same cycle, the flag ends up set.
- R9: Every capture overwrites the stored value, even if it was never read. Without a capture the value holds.
- R10: With `pin_out_mode_i` at 1 the edge detector watches `port_val_i` and ignores `pin_i`. With it at 0 the detector watches `pin_i` and ignores `port_val_i`.
- R11: The mode register loads `mode_wdata_i` at the edge where `mode_wr_i` is 1 and keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External input pin |
| pin_out_mode_i | input | 1 | 1: port drives the pin, so the port value feeds the edge detector |
| port_val_i | input | 1 | Port output data value |
| timer_i | input | 16 | Free-running timer value |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 4 | Mode register write data |
| flag_clr_i | input | 1 | Software clear of the capture flag |
| cap_hi_o | output | 8 | Captured timer value, high byte |
| cap_lo_o | output | 8 | Captured timer value, low byte |
| flag_o | output | 1 | Capture-done interrupt flag |

## Verification
On every cycle, the assertions check these relations: a capture loads the timer value, the stored value holds when there is no capture, the flag keeps its state or gives way to a clear, a capture wins over a clear in the same cycle, the prescaler clears and captures stop in non-capture modes, and the mode register loads correctly. Some behaviour depends on a whole history of edges, and only the bench scenarios can show it. This covers the two-edge delay from the source to the capture, the exact rising edge on which a divide-by-4 or divide-by-16 capture lands, the early capture after a direct change between prescaler modes, and the choice between the pin and the port value.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF   = 4'b0000,
        MODE_FALL  = 4'b0100,
        MODE_RISE  = 4'b0101,
        MODE_DIV4  = 4'b0110,
        MODE_DIV16 = 4'b0111
    } cap_mode_e;

    // Capture modes occupy the 01xx group of codes
    function automatic logic is_capture(input logic [MODE_W-1:0] m);
        return (m[3:2] == 2'b01);
    endfunction

endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb chain_d[0] = d_i;

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            always_comb chain_d[gi] = chain_q[gi-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/icu_edge.sv
module icu_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
        fall_o = ~level_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/icu_presc.sv
module icu_presc
    import icu_pkg::*;
#(
    parameter int PRESC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              event_o,
    output logic [PRESC_W-1:0] cnt_o
);

    localparam int DIV4_BITS  = 2;
    localparam int DIV16_BITS = 4;

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } presc_t;

    presc_t st_d;
    presc_t st_q;
    logic   div4_hit;
    logic   div16_hit;

    always_comb begin
        div4_hit  = &st_q.cnt[DIV4_BITS-1:0];
        div16_hit = &st_q.cnt[DIV16_BITS-1:0];

        st_d = st_q;
        if (!is_capture(mode_i)) begin
            st_d.cnt = '0;
        end else if (rise_i) begin
            st_d.cnt = st_q.cnt + {{(PRESC_W-1){1'b0}}, 1'b1};
        end

        unique case (mode_i)
            MODE_FALL:  event_o = fall_i;
            MODE_RISE:  event_o = rise_i;
            MODE_DIV4:  event_o = rise_i & div4_hit;
            MODE_DIV16: event_o = rise_i & div16_hit;
            default:    event_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
    import icu_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PRESC_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic               pin_out_mode_i,
    input  logic               port_val_i,
    input  logic [TMR_W-1:0]   timer_i,
    input  logic               mode_wr_i,
    input  logic [MODE_W-1:0]  mode_wdata_i,
    input  logic               flag_clr_i,
    output logic [TMR_W/2-1:0] cap_hi_o,
    output logic [TMR_W/2-1:0] cap_lo_o,
    output logic               flag_o
);

    localparam int HALF_W = TMR_W / 2;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [TMR_W-1:0]  cap;
        logic              flag;
    } unit_t;

    unit_t              st_d;
    unit_t              st_q;
    logic               src_level;
    logic               sync_level;
    logic               edge_rise;
    logic               edge_fall;
    logic               cap_event;
    logic [PRESC_W-1:0] presc_cnt;
    logic [MODE_W-1:0]  mode_q;

    // Source select: the port value when the pin is driven as an output
    always_comb src_level = pin_out_mode_i ? port_val_i : pin_i;

    icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_level),
        .q_o   (sync_level)
    );

    icu_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_level),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    icu_presc #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (st_q.mode),
        .rise_i  (edge_rise),
        .fall_i  (edge_fall),
        .event_o (cap_event),
        .cnt_o   (presc_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (mode_wr_i) st_d.mode = mode_wdata_i;
        if (cap_event) st_d.cap  = timer_i;
        // A capture in the same cycle as a clear leaves the flag set
        if (cap_event)       st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_q   = st_q.mode;
    assign cap_hi_o = st_q.cap[TMR_W-1:HALF_W];
    assign cap_lo_o = st_q.cap[HALF_W-1:0];
    assign flag_o   = st_q.flag;

endmodule

// File: rtl/icu_checker.sv
module icu_checker
    import icu_pkg::*;
#(
    parameter int TMR_W   = 16,
    parameter int PRESC_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TMR_W-1:0]   timer_i,
    input logic               mode_wr_i,
    input logic [MODE_W-1:0]  mode_wdata_i,
    input logic               flag_clr_i,
    input logic [TMR_W/2-1:0] cap_hi_o,
    input logic [TMR_W/2-1:0] cap_lo_o,
    input logic               flag_o,
    input logic [MODE_W-1:0]  mode_q,
    input logic               cap_event,
    input logic [PRESC_W-1:0] presc_cnt
);

    a_r2_no_event_outside_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode_q) |-> !cap_event);

    a_r6_presc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode_q) |=> (presc_cnt == '0));

    a_r3_capture_takes_timer: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |=> ({cap_hi_o, cap_lo_o} == $past(timer_i)));

    a_r9_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_event |=> $stable({cap_hi_o, cap_lo_o}));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

    a_r7_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !cap_event) |=> !flag_o);

    a_r8_capture_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |=> flag_o);

    a_r11_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_i |=> (mode_q == $past(mode_wdata_i)));

    a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_i |=> $stable(mode_q));

endmodule

bind tmr_capture_unit icu_checker #(.TMR_W(TMR_W), .PRESC_W(PRESC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .timer_i      (timer_i),
    .mode_wr_i    (mode_wr_i),
    .mode_wdata_i (mode_wdata_i),
    .flag_clr_i   (flag_clr_i),
    .cap_hi_o     (cap_hi_o),
    .cap_lo_o     (cap_lo_o),
    .flag_o       (flag_o),
    .mode_q       (mode_q),
    .cap_event    (cap_event),
    .presc_cnt    (presc_cnt)
);

// File: tb/tmr_capture_unit_tb.sv
`timescale 1ns/1ps
module tmr_capture_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic        pin_out_mode = 1'b0;
    logic        port_val = 1'b0;
    logic [15:0] tmr = 16'h0;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_wdata = 4'h0;
    logic        flag_clr = 1'b0;
    logic [7:0]  cap_hi;
    logic [7:0]  cap_lo;
    logic        flag;

    int  checks = 0;
    int  failures = 0;
    bit  auto_tmr = 1'b0;
    bit  cmp_en = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    tmr_capture_unit u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_i          (pin),
        .pin_out_mode_i (pin_out_mode),
        .port_val_i     (port_val),
        .timer_i        (tmr),
        .mode_wr_i      (mode_wr),
        .mode_wdata_i   (mode_wdata),
        .flag_clr_i     (flag_clr),
        .cap_hi_o       (cap_hi),
        .cap_lo_o       (cap_lo),
        .flag_o         (flag)
    );

    // Reference model written from the requirements
    logic        m_s1, m_s2, m_prev, m_flag;
    logic [3:0]  m_mode, m_cnt;
    logic [15:0] m_cap;

    function automatic bit ref_capmode(input logic [3:0] m);
        return (m == 4'h4) || (m == 4'h5) || (m == 4'h6) || (m == 4'h7);
    endfunction

    function automatic bit ref_event(input logic [3:0] m, input logic [3:0] c,
                                     input bit r, input bit f);
        case (m)
            4'h4:    return f;
            4'h5:    return r;
            4'h6:    return r && (c[1:0] == 2'd3);
            4'h7:    return r && (c == 4'd15);
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0;
            m_mode <= 0; m_cnt <= 0; m_cap <= 0;
        end else begin
            automatic bit r = m_s2 && !m_prev;
            automatic bit f = !m_s2 && m_prev;
            automatic bit ev = ref_event(m_mode, m_cnt, r, f);
            m_s1   <= pin_out_mode ? port_val : pin;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_cnt  <= !ref_capmode(m_mode) ? 4'd0 : (r ? m_cnt + 4'd1 : m_cnt);
            if (mode_wr) m_mode <= mode_wdata;
            if (ev) m_cap <= tmr;
            m_flag <= ev ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
        end
    end

    always @(negedge clk) if (auto_tmr) tmr <= tmr + 16'd1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (cmp_en) begin
        chk("R9 model capture value", {cap_hi, cap_lo}, m_cap);
        chk("R7 model flag", flag, m_flag);
    end

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic drive_src(input logic v);
        @(negedge clk);
        if (pin_out_mode) port_val = v; else pin = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse();
        drive_src(1'b1);
        drive_src(1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 cap after reset", {cap_hi, cap_lo}, 32'h0);
        chk("R1 flag after reset", flag, 1'b0);
        cmp_en = 1'b1;

        // R2: off and non-capture codes never capture
        pulse();
        chk("R2 off mode no flag", flag, 1'b0);
        set_mode(4'b0001);
        pulse();
        chk("R2 code 0001 no flag", flag, 1'b0);
        set_mode(4'b1101);
        pulse();
        chk("R2 code 1101 no flag", flag, 1'b0);

        // R11: data without write strobe is ignored
        set_mode(4'h0);
        @(negedge clk); mode_wdata = 4'b0101;
        pulse();
        chk("R11 no strobe no capture", flag, 1'b0);

        // R3 / R4: rising mode, exact latency and byte split
        set_mode(4'b0101);
        @(negedge clk); pin = 1'b1; tmr = 16'hA000;
        @(negedge clk); tmr = 16'hA001;
        chk("R3 flag not early", flag, 1'b0);
        @(negedge clk); tmr = 16'hA002;
        @(negedge clk); tmr = 16'hA003;
        chk("R3 cap_hi byte", cap_hi, 8'hA0);
        chk("R3 cap_lo byte", cap_lo, 8'h02);
        chk("R3 flag after capture", flag, 1'b1);
        clear_flag();
        chk("R7 clear drops flag", flag, 1'b0);
        drive_src(1'b0);
        chk("R4 falling edge ignored in rising mode", flag, 1'b0);

        // R4: falling mode
        set_mode(4'b0100);
        tmr = 16'h1234;
        drive_src(1'b1);
        chk("R4 rising edge ignored in falling mode", flag, 1'b0);
        drive_src(1'b0);
        chk("R4 falling edge captures", flag, 1'b1);
        chk("R4 falling capture value", {cap_hi, cap_lo}, 16'h1234);

        // R9: overwrite without read
        tmr = 16'h5678;
        pulse();
        chk("R9 second capture overwrites", {cap_hi, cap_lo}, 16'h5678);
        chk("R7 flag stays without clear", flag, 1'b1);

        // R8: capture and clear in the same cycle
        set_mode(4'b0101);
        tmr = 16'h9ABC;
        @(negedge clk); pin = 1'b1;
        @(negedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R8 capture wins over clear", flag, 1'b1);
        chk("R8 value captured", {cap_hi, cap_lo}, 16'h9ABC);
        drive_src(1'b0);

        // R5: divide by 4
        set_mode(4'h0);
        set_mode(4'b0110);
        clear_flag();
        repeat (3) pulse();
        chk("R5 no capture after 3 rising edges", flag, 1'b0);
        pulse();
        chk("R5 capture on 4th rising edge", flag, 1'b1);
        clear_flag();
        repeat (3) pulse();
        chk("R5 no capture at 7th", flag, 1'b0);
        pulse();
        chk("R5 capture on 8th", flag, 1'b1);

        // R5: divide by 16
        set_mode(4'h0);
        set_mode(4'b0111);
        clear_flag();
        repeat (15) pulse();
        chk("R5 no capture after 15 rising edges", flag, 1'b0);
        pulse();
        chk("R5 capture on 16th rising edge", flag, 1'b1);

        // R6: direct switch keeps the count, off clears it
        set_mode(4'h0);
        set_mode(4'b0111);
        repeat (5) pulse();
        set_mode(4'b0110);
        clear_flag();
        repeat (2) pulse();
        chk("R6 no capture after 2 edges post switch", flag, 1'b0);
        pulse();
        chk("R6 early capture on 3rd edge post switch", flag, 1'b1);
        set_mode(4'b0111);
        repeat (5) pulse();
        set_mode(4'h0);
        set_mode(4'b0110);
        clear_flag();
        repeat (3) pulse();
        chk("R6 cleared count needs 4 edges", flag, 1'b0);
        pulse();
        chk("R6 cleared count capture on 4th", flag, 1'b1);

        // R10: port value as source
        set_mode(4'b0101);
        clear_flag();
        @(negedge clk); pin_out_mode = 1'b1;
        repeat (3) @(negedge clk);
        @(negedge clk); pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 pin ignored in output mode", flag, 1'b0);
        tmr = 16'h4242;
        drive_src(1'b1);
        chk("R10 port write captures", flag, 1'b1);
        chk("R10 port capture value", {cap_hi, cap_lo}, 16'h4242);
        drive_src(1'b0);
        clear_flag();
        @(negedge clk); pin_out_mode = 1'b0; pin = 1'b0;
        repeat (3) @(negedge clk);
        clear_flag();
        @(negedge clk); port_val = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 port ignored in input mode", flag, 1'b0);

        // Random phase against the model, fixed seed
        begin
            automatic int unsigned seed = $urandom(32'h1CAB);
            automatic logic [3:0] codes [7] = '{4'h0, 4'h4, 4'h5, 4'h6, 4'h7, 4'h1, 4'h9};
            auto_tmr = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                @(negedge clk);
                seed = $urandom;
                pin          = seed[0] ^ seed[5];
                port_val     = seed[1];
                pin_out_mode = (seed[13:8] == 6'd0) ? ~pin_out_mode : pin_out_mode;
                flag_clr     = (seed[19:16] == 4'd0);
                mode_wr      = (seed[27:22] == 6'd0);
                mode_wdata   = codes[seed[30:28] % 7];
            end
            @(negedge clk);
            mode_wr = 1'b0; flag_clr = 1'b0;
            repeat (4) @(negedge clk);
        end

        finish_run();
    end

endmodule